// File: doc/BRIEF.md
# Multi-Hart Machine Timer Bank

This block keeps one shared 64-bit real-time counter and a 64-bit deadline register for each hart. Each hart has a level-sensitive timer interrupt output. The output is high while that hart's deadline is at or below the current count. The counter advances by one in every clock cycle in which the tick-enable input is high. The tick source lives outside this block.

Software reaches the registers over a simple register bus. Each request carries a byte address, a size bit that selects 4 or 8 bytes, write data, and a read/write flag. Each 64-bit register can be accessed as two 32-bit halves or as a whole word. A 32-bit write replaces only the addressed half and keeps the other half. Writing the counter re-evaluates every hart's interrupt in the same cycle. Deadlines are placed at a compare base with an 8-byte stride per hart. The counter has a base of its own.

Top module: `hart_timer_bank`

## Requirements
- R1: After synchronous reset the counter is zero, every deadline reads as all ones, every interrupt output is low, and the read data output is zero.
- R2: The counter grows by exactly one in each cycle where the tick-enable input is high and no counter write occurs. In all other cycles it holds its value.
- R3: The deadline of hart i is mapped at CMP_BASE + 8*i for i below NUM_HARTS. An 8-byte access at that address writes or returns all 64 bits.
- R4: A 4-byte access at a register's 8-aligned address reaches bits 31:0, and one at address +4 reaches bits 63:32. Write data is taken from wdata[31:0], and read data returns in rdata[31:0] with the upper 32 bits zero. A 4-byte write keeps the other half unchanged.
- R5: The interrupt of a hart is high exactly when its deadline is less than or equal to the counter, equality included. The output changes on the same clock edge that stores the write or tick that caused the change, so it is visible one cycle after the request. It drops when a deadline write moves the deadline past the counter.
- R6: A counter write (8-byte at TIME_BASE, or 4-byte at TIME_BASE or TIME_BASE+4) takes priority over a tick in the same cycle. It re-evaluates the interrupt of every hart against the new value.
- R7: An 8-byte access addressed at offset +4 of a deadline or of the counter is rejected. A write changes no state, and a read returns zero.
- R8: An access outside the deadline window and the counter register, or one whose addr[1:0] is not zero, returns zero on a read and changes nothing on a write.
- R9: Read data is registered. It appears on rsp_rdata in the cycle after the read request and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_wdata | input | 64 | Write data (little-endian) |
| rsp_rdata | output | 64 | Registered read data |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt levels |

## Verification
The assertions assume the following about the parameters:
- CMP_BASE and TIME_BASE are multiples of 8.
- The deadline window and the counter register do not overlap.

One assertion checks the second point directly. The assertions also assume that bus inputs are stable around each rising edge. The bench changes every input only on the falling edge and keeps tick_en low except in the cycles where a counter step is intended. Every address it drives lies either inside one of the two windows or in an unmapped gap that it picks on purpose.

// File: rtl/htb_pkg.sv
package htb_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_FULL = 2'd3
  } acc_kind_e;

  // Combine an existing 64-bit value with bus write data per access kind.
  function automatic logic [WORD_W-1:0] merge_word(
    input logic [WORD_W-1:0] old_v,
    input logic [WORD_W-1:0] wd,
    input acc_kind_e         k
  );
    logic [WORD_W-1:0] r;
    case (k)
      ACC_LO:   r = {old_v[WORD_W-1:HALF_W], wd[HALF_W-1:0]};
      ACC_HI:   r = {wd[HALF_W-1:0], old_v[HALF_W-1:0]};
      ACC_FULL: r = wd;
      default:  r = old_v;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/htb_decode.sv
module htb_decode
  import htb_pkg::*;
#(
  parameter int                NUM_HARTS = 4,
  parameter int                ADDR_W    = 16,
  parameter int                IDX_W     = 2,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size8_i,
  output logic              cmp_hit_o,
  output logic              time_hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output acc_kind_e         kind_o
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot_off;

  always_comb begin
    slot_off   = addr_i[ADDR_W-1:3] - CMP_BASE[ADDR_W-1:3];
    cmp_hit_o  = (addr_i >= CMP_BASE) && (slot_off < SLOT_W'(NUM_HARTS));
    time_hit_o = (addr_i[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]);
    idx_o      = slot_off[IDX_W-1:0];
    if (addr_i[1:0] != 2'b00)            kind_o = ACC_NONE;
    else if (size8_i && addr_i[2])       kind_o = ACC_NONE;
    else if (size8_i)                    kind_o = ACC_FULL;
    else if (addr_i[2])                  kind_o = ACC_HI;
    else                                 kind_o = ACC_LO;
  end
endmodule

// File: rtl/htb_time_counter.sv
module htb_time_counter
  import htb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_i,
  input  acc_kind_e         kind_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] time_q_o,
  output logic [WORD_W-1:0] time_d_o
);
  logic [WORD_W-1:0] time_q;

  always_comb begin
    if (wr_i)        time_d_o = merge_word(time_q, wdata_i, kind_i);
    else if (tick_i) time_d_o = time_q + WORD_W'(1);
    else             time_d_o = time_q;
  end

  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else     time_q <= time_d_o;
  end

  assign time_q_o = time_q;

  // R1: reset leaves the counter at zero
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> time_q == '0);
  // R2: a tick without a write advances by one
  p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !wr_i) |=> time_q == $past(time_q) + WORD_W'(1));
  // R2: no tick and no write holds the value
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !wr_i) |=> $stable(time_q));
  // R6: a full write wins over a tick
  p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_i && kind_i == ACC_FULL) |=> time_q == $past(wdata_i));
endmodule

// File: rtl/htb_cmp_slot.sv
module htb_cmp_slot
  import htb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  acc_kind_e         kind_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] time_d_i,
  input  logic [WORD_W-1:0] time_q_i,
  output logic [WORD_W-1:0] cmp_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] cmp_q;
  logic [WORD_W-1:0] cmp_d;
  logic              irq_q;

  always_comb begin
    cmp_d = wr_i ? merge_word(cmp_q, wdata_i, kind_i) : cmp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      irq_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      irq_q <= (cmp_d <= time_d_i);
    end
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  // R5: the registered level always agrees with the stored deadline and counter
  p_irq_level_r5: assert property (@(posedge clk) disable iff (rst)
    irq_q == (cmp_q <= time_q_i));
  // R3: a deadline only changes when its own slot is written
  p_cmp_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(cmp_q));
  // R1: reset leaves the deadline at all ones
  p_reset_ones_r1: assert property (@(posedge clk) rst |=> cmp_q == '1 && !irq_q);
endmodule

// File: rtl/hart_timer_bank.sv
module hart_timer_bank
  import htb_pkg::*;
#(
  parameter int                NUM_HARTS = 4,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h0000,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'h0100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_size8,
  input  logic [63:0]          req_wdata,
  output logic [63:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] timer_irq
);
  localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  logic              cmp_hit;
  logic              time_hit;
  logic [IDX_W-1:0]  idx;
  acc_kind_e         kind;
  logic              wr_ok;
  logic              time_wr;
  logic [WORD_W-1:0] time_q;
  logic [WORD_W-1:0] time_d;
  logic [WORD_W-1:0] cmp_val [NUM_HARTS];
  logic [WORD_W-1:0] sel_val;
  logic [WORD_W-1:0] rd_val;
  logic [WORD_W-1:0] rdata_q;

  htb_decode #(
    .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
  ) u_dec (
    .addr_i(req_addr), .size8_i(req_size8),
    .cmp_hit_o(cmp_hit), .time_hit_o(time_hit), .idx_o(idx), .kind_o(kind)
  );

  assign wr_ok   = req_valid && req_write && (kind != ACC_NONE);
  assign time_wr = wr_ok && time_hit;

  htb_time_counter u_time (
    .clk(clk), .rst(rst), .tick_i(tick_en), .wr_i(time_wr),
    .kind_i(kind), .wdata_i(req_wdata), .time_q_o(time_q), .time_d_o(time_d)
  );

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_slot
    logic slot_wr;
    assign slot_wr = wr_ok && cmp_hit && !time_hit && (idx == IDX_W'(g));
    htb_cmp_slot u_slot (
      .clk(clk), .rst(rst), .wr_i(slot_wr), .kind_i(kind),
      .wdata_i(req_wdata), .time_d_i(time_d), .time_q_i(time_q),
      .cmp_o(cmp_val[g]), .irq_o(timer_irq[g])
    );
  end

  always_comb begin
    sel_val = '0;
    if (time_hit)     sel_val = time_q;
    else if (cmp_hit) sel_val = cmp_val[idx];
    case (kind)
      ACC_LO:   rd_val = {{HALF_W{1'b0}}, sel_val[HALF_W-1:0]};
      ACC_HI:   rd_val = {{HALF_W{1'b0}}, sel_val[WORD_W-1:HALF_W]};
      ACC_FULL: rd_val = sel_val;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                         rdata_q <= '0;
    else if (req_valid && !req_write) rdata_q <= rd_val;
  end

  assign rsp_rdata = rdata_q;

  // R8: a read that hits nothing returns zero next cycle
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !cmp_hit && !time_hit) |=> rsp_rdata == '0);
  // R7: a wide access at a high half is refused and returns zero
  p_wide_hi_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size8 && req_addr[2]) |=> rsp_rdata == '0);
  // Parameter assumption: windows never overlap
  p_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(cmp_hit && time_hit));
  // R9: read data holds while no read is issued
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));
endmodule

// File: tb/hart_timer_bank_test.sv
module hart_timer_bank_test;
  localparam int NH = 4;
  localparam logic [15:0] TB = 16'h0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_size8 = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata;
  logic [NH-1:0] timer_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic pend = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  hart_timer_bank #(.NUM_HARTS(NH), .ADDR_W(16), .CMP_BASE(16'h0000), .TIME_BASE(TB)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size8(req_size8),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .timer_irq(timer_irq)
  );

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: read results arrive one cycle after the request
  always @(posedge clk) pend <= req_valid && !req_write && !rst;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: unexpected read result %h expected none", rsp_rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata, e, t);
      end
    end
  end

  task automatic rd(input logic [15:0] a, input logic s8, input logic [63:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size8 = s8;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic s8, input logic [63:0] d, input logic tk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size8 = s8;
    req_wdata = d; tick_en = tk;
    @(negedge clk);
    req_valid = 1'b0; tick_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check({60'b0, timer_irq}, 64'h0, "R1 irq after reset");
    check(rsp_rdata, 64'h0, "R1 rdata after reset");
    rd(TB, 1'b1, 64'h0, "R1 counter zero");
    rd(16'h0008, 1'b1, '1, "R1 deadline all ones");
    // R3 full deadline write
    wr(16'h0000, 1'b1, 64'd5, 1'b0);
    check({60'b0, timer_irq}, 64'h0, "R5 deadline 5 ahead of counter 0");
    rd(16'h0000, 1'b1, 64'd5, "R3 hart0 full readback");
    // R4 half writes
    wr(16'h0010, 1'b0, 64'h1234_5678_DEAD_BEEF, 1'b0);
    rd(16'h0014, 1'b0, 64'h0000_0000_FFFF_FFFF, "R4 high half kept");
    rd(16'h0010, 1'b0, 64'h0000_0000_DEAD_BEEF, "R4 low half written");
    // R2 ten ticks
    @(negedge clk); tick_en = 1'b1;
    repeat (10) @(negedge clk);
    tick_en = 1'b0;
    check({60'b0, timer_irq}, 64'h1, "R5 hart0 fires at counter 10");
    rd(TB, 1'b0, 64'd10, "R2 counter after ten ticks");
    // R5 deassert by moving deadline forward via high half
    wr(16'h0004, 1'b0, 64'h1, 1'b0);
    check({60'b0, timer_irq}, 64'h0, "R5 hart0 drops when deadline moved ahead");
    // R5 equality boundary
    wr(16'h0008, 1'b1, 64'd10, 1'b0);
    check({60'b0, timer_irq}, 64'h2, "R5 equal deadline fires");
    wr(16'h0008, 1'b1, 64'd11, 1'b0);
    check({60'b0, timer_irq}, 64'h0, "R5 deadline one above");
    // R6 counter write re-evaluates all harts
    wr(TB, 1'b1, 64'h1_0000_0005, 1'b0);
    check({60'b0, timer_irq}, 64'h3, "R6 all harts re-evaluated");
    // R6 write beats tick
    wr(TB, 1'b0, 64'h20, 1'b1);
    rd(TB, 1'b1, 64'h1_0000_0020, "R6 low-half write wins over tick");
    wr(TB + 16'h4, 1'b0, 64'h0, 1'b0);
    check({60'b0, timer_irq}, 64'h2, "R6 high-half write drops hart0");
    rd(TB, 1'b1, 64'h20, "R6 merged counter");
    // R7 wide access at +4
    wr(16'h0004, 1'b1, 64'h0, 1'b0);
    rd(16'h0000, 1'b1, 64'h1_0000_0005, "R7 wide high write ignored");
    check({60'b0, timer_irq}, 64'h2, "R7 irq unchanged");
    rd(TB + 16'h4, 1'b1, 64'h0, "R7 wide high read zero");
    wr(TB + 16'h4, 1'b1, 64'h0, 1'b0);
    rd(TB, 1'b1, 64'h20, "R7 counter unchanged");
    // R8 unmapped and misaligned
    rd(16'h0080, 1'b1, 64'h0, "R8 gap read zero");
    wr(16'h0080, 1'b1, 64'h0, 1'b0);
    rd(16'h0020, 1'b1, 64'h0, "R8 past last hart reads zero");
    rd(16'h0018, 1'b1, '1, "R3 last hart mapped");
    wr(TB + 16'h2, 1'b0, 64'h0, 1'b0);
    rd(TB + 16'h2, 1'b0, 64'h0, "R8 misaligned read zero");
    rd(TB, 1'b1, 64'h20, "R8 misaligned write ignored");
    // R9 hold between reads
    @(negedge clk);
    check(rsp_rdata, 64'h20, "R9 rdata held");
    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check({60'b0, timer_irq}, 64'h0, "R1 irq cleared by reset");
    rd(TB, 1'b1, 64'h0, "R1 counter cleared by reset");
    rd(16'h0008, 1'b1, '1, "R1 deadline restored");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R9: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule